// File: doc/BRIEF.md
# UART Receive Queue with Character Timeout

This block is the receive side of a 16550-style serial port, placed between the receive shifter and the register file. The shifter hands over one byte, or one break event, per valid pulse. Register reads of the receive data location pop the queue. Writes to the FIFO control register pick the mode, the trigger level and the clear actions. The block keeps the data-ready, overrun and break flags. It raises a trigger-reached output when enough bytes are waiting. It flags a character timeout when data has sat unread for four character times, counted in baud-rate bit ticks.

The byte input is valid-only and has no back-pressure. A character that has come off the line cannot be held back, so the block takes every valid pulse. When the queue is full the byte is thrown away and the overrun flag records the loss. With the queue disabled, a single holding byte stands in for it. The frame settings from the line control register set the length of a character in bits, and that length sets the timeout window.

Top module: `uart_rx_fifo_ctl`

## Requirements
- R1: `trig_hit` is a register. In queue mode it is high when the count is at least the level that FCR bits 7:6 select: 1, 4, 8 or 14 bytes for codes 0, 1, 2 and 3. In holding mode it follows `data_ready`.
- R2: In queue mode, a byte or break that arrives while the queue holds DEPTH entries and no read occurs in the same cycle is dropped. The stored entries and their order are kept, and `overrun` is set.
- R3: In queue mode, every accepted arrival restarts the timeout window, and so does every read that leaves data in the queue. When 4×(character bits) baud ticks have been seen since the last restart and the count is non-zero, `timeout_pend` is set.
- R4: A read in queue mode pops the oldest byte, shown on `rd_data` during the read cycle, and clears `timeout_pend`. A read that leaves the queue empty also clears `data_ready` and `brk_seen`. `rd_data` is 0 while the queue is empty.
- R5: A control write with bit 1 set empties the queue and clears `data_ready`, `brk_seen` and `timeout_pend`.
- R6: A control write with bit 2 set gives a one-cycle `tx_fifo_clr` pulse in the next cycle. A write that changes bit 0 (enable, shown on `fifo_en`) acts as though bits 1 and 2 were both set.
- R7: `fcr_q` keeps only bits 7, 6, 3 and 0 of the last control write; all other bits read 0.
- R8: A break event stores a zero byte in the same way as a received byte, and sets `brk_seen` and `data_ready`.
- R9: A character is 1 start bit, plus 5 to 8 data bits (5 + `lcr_frame[1:0]`), plus one parity bit when `lcr_frame[3]` is 1, plus 1 stop bit (2 when `lcr_frame[2]` is 1).
- R10: An `lsr_rd` pulse clears `overrun` and `brk_seen`. A flag set by an event in the same cycle wins over the clear.
- R11: In holding mode (bit 0 clear), an arrival overwrites the single holding byte and sets `data_ready`. If `data_ready` was already set and no read occurs in the same cycle, it also sets `overrun`. A read returns the holding byte and clears `data_ready` and `brk_seen`.
- R12: After reset, `rx_count`, all flags, `fcr_q`, `trig_hit` and `rd_data` are 0. `rx_count` is a register. A control write takes priority over any arrival or read in the same cycle, and that arrival or read is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Arrival from the shifter, always accepted |
| in_brk | input | 1 | With in_valid: the arrival is a break event |
| in_data | input | 8 | Received byte |
| rd_en | input | 1 | Read of the receive data location |
| rd_data | output | 8 | Byte returned by a read |
| lsr_rd | input | 1 | Read of the line status location |
| fcr_we | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write data |
| fcr_q | output | 8 | Kept control bits |
| lcr_frame | input | 4 | Frame settings, line control bits 3:0 |
| baud_tick | input | 1 | One pulse per bit time |
| fifo_en | output | 1 | Queue mode active |
| rx_count | output | CW | Entries held (CW = log2(DEPTH)+1) |
| trig_hit | output | 1 | Trigger level reached |
| data_ready | output | 1 | Receive data available |
| overrun | output | 1 | A character was lost |
| brk_seen | output | 1 | Break received |
| timeout_pend | output | 1 | Character timeout pending |
| tx_fifo_clr | output | 1 | Pulse to clear the transmit queue |

## Verification
The bench fills the queue past DEPTH and then reads it back. A design that wrote the dropped bytes over older entries would return the wrong sequence on the later reads. It counts bit ticks for three frame formats and checks `timeout_pend` both one tick before the window closes and on the tick that closes it. An off-by-one window, or a wrong character length, shows up as an early or late flag. A read that leaves data behind must restart the window, so a design that does not restart on reads would flag too soon. It also covers a break followed by a status read, a transmit-only clear that must leave the receive count alone, and overrun in holding mode. Random mixes of arrivals, reads, breaks and status reads, run at each trigger level, catch errors in the flag priorities.

// File: rtl/uart_rxq_pkg.sv
`timescale 1ns/1ps
package uart_rxq_pkg;
  localparam logic [7:0] FCR_KEEP = 8'hC9;
  localparam int FCR_EN_BIT    = 0;
  localparam int FCR_RXCLR_BIT = 1;
  localparam int FCR_TXCLR_BIT = 2;

  typedef struct packed {
    logic ready;
    logic ovr;
    logic brk;
    logic tmo;
  } rxq_flags_t;

  // trigger level in bytes for the two-bit code in FCR[7:6]
  function automatic logic [4:0] level_of(input logic [1:0] code);
    case (code)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  // bits per character: start + data + optional parity + stop
  function automatic logic [3:0] frame_bits(input logic [3:0] lc);
    logic [3:0] b;
    b = 4'd6 + {2'b00, lc[1:0]};
    b = b + {3'b000, lc[3]} + (lc[2] ? 4'd2 : 4'd1);
    return b;
  endfunction
endpackage

// File: rtl/rxq_store.sv
`timescale 1ns/1ps
module rxq_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] slot [DEPTH];
  logic [AW-1:0] rp, wp;
  logic          pop_ok, push_ok;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign head    = slot[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    if (clr) count_nxt = '0;
    else     count_nxt = count + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp    <= '0;
      wp    <= '0;
      count <= '0;
    end else begin
      count <= count_nxt;
      if (clr) begin
        rp <= '0;
        wp <= '0;
      end else begin
        if (pop_ok)  rp <= bump(rp);
        if (push_ok) wp <= bump(wp);
      end
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push_ok && !clr && wp == AW'(i)) slot[i] <= wdata;
    end
  end

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  assert_keep_on_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> (full && $stable(rp) && $stable(wp)));
endmodule

// File: rtl/rxq_timer.sv
`timescale 1ns/1ps
module rxq_timer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic       cancel,
  input  logic       tick,
  input  logic [3:0] char_bits,
  output logic       expire
);
  localparam int TW = 6;
  logic [TW-1:0] limit, cnt;
  logic          armed;

  assign limit  = {char_bits, 2'b00};
  assign expire = armed && tick && !restart && !cancel && ((cnt + TW'(1)) >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (cancel) begin
      armed <= 1'b0;
      cnt   <= '0;
    end else if (restart) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (armed && tick) begin
      if (expire) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + TW'(1);
      end
    end
  end

  assert_restart_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !expire);
  assert_single_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire);
endmodule

// File: rtl/rxq_fcr_dec.sv
`timescale 1ns/1ps
module rxq_fcr_dec
  import uart_rxq_pkg::*;
(
  input  logic       we,
  input  logic [7:0] wdata,
  input  logic       cur_en,
  output logic       rx_clr,
  output logic       tx_clr,
  output logic [7:0] fcr_new
);
  logic en_flip;

  assign en_flip = we && (wdata[FCR_EN_BIT] != cur_en);
  assign rx_clr  = (we && wdata[FCR_RXCLR_BIT]) || en_flip;
  assign tx_clr  = (we && wdata[FCR_TXCLR_BIT]) || en_flip;
  assign fcr_new = wdata & FCR_KEEP;
endmodule

// File: rtl/uart_rx_fifo_ctl.sv
`timescale 1ns/1ps
module uart_rx_fifo_ctl
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_brk,
  input  logic [7:0]    in_data,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  input  logic          lsr_rd,
  input  logic          fcr_we,
  input  logic [7:0]    fcr_wdata,
  output logic [7:0]    fcr_q,
  input  logic [3:0]    lcr_frame,
  input  logic          baud_tick,
  output logic          fifo_en,
  output logic [CW-1:0] rx_count,
  output logic          trig_hit,
  output logic          data_ready,
  output logic          overrun,
  output logic          brk_seen,
  output logic          timeout_pend,
  output logic          tx_fifo_clr
);
  logic [7:0]    fcr_r, fcr_new, hold, in_byte, head;
  logic          rx_clr_c, tx_clr_c, tx_r, trig_r;
  logic          live, q_push, q_pop, nf_push, nf_rd;
  logic          q_full, q_empty, q_drains, ovr_evt, restart, expire;
  logic [CW-1:0] cnt_nxt;
  rxq_flags_t    flg, flg_n;
  logic          en_n;
  logic [1:0]    lvl_code_n;

  rxq_fcr_dec u_dec (
    .we      (fcr_we),
    .wdata   (fcr_wdata),
    .cur_en  (fcr_r[FCR_EN_BIT]),
    .rx_clr  (rx_clr_c),
    .tx_clr  (tx_clr_c),
    .fcr_new (fcr_new)
  );

  assign live    = !fcr_we;
  assign in_byte = in_brk ? 8'h00 : in_data;
  assign q_push  = live && fcr_r[FCR_EN_BIT] && in_valid;
  assign q_pop   = live && fcr_r[FCR_EN_BIT] && rd_en;
  assign nf_push = live && !fcr_r[FCR_EN_BIT] && in_valid;
  assign nf_rd   = live && !fcr_r[FCR_EN_BIT] && rd_en;

  rxq_store #(.DEPTH(DEPTH), .DW(8)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (rx_clr_c),
    .push      (q_push),
    .pop       (q_pop),
    .wdata     (in_byte),
    .head      (head),
    .count     (rx_count),
    .count_nxt (cnt_nxt),
    .full      (q_full),
    .empty     (q_empty)
  );

  // a read that leaves nothing behind; an arrival in the same cycle refills
  assign q_drains = q_pop && (rx_count <= CW'(1)) && !q_push;
  assign restart  = q_push || (q_pop && (rx_count > CW'(1)));
  assign ovr_evt  = (q_push && q_full && !q_pop) || (nf_push && flg.ready && !nf_rd);

  rxq_timer u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .cancel    (rx_clr_c),
    .tick      (baud_tick),
    .char_bits (frame_bits(lcr_frame)),
    .expire    (expire)
  );

  always_comb begin
    flg_n = flg;
    if (lsr_rd) begin
      flg_n.brk = 1'b0;
      flg_n.ovr = 1'b0;
    end
    if (rx_clr_c) begin
      flg_n.ready = 1'b0;
      flg_n.brk   = 1'b0;
      flg_n.tmo   = 1'b0;
    end else begin
      if (q_pop)                      flg_n.tmo = 1'b0;
      else if (expire && !q_empty)    flg_n.tmo = 1'b1;
      if (q_drains || nf_rd) begin
        flg_n.ready = 1'b0;
        flg_n.brk   = 1'b0;
      end
      if (q_push || nf_push) begin
        flg_n.ready = 1'b1;
        if (in_brk) flg_n.brk = 1'b1;
      end
    end
    if (ovr_evt) flg_n.ovr = 1'b1;
  end

  assign en_n       = fcr_we ? fcr_new[FCR_EN_BIT] : fcr_r[FCR_EN_BIT];
  assign lvl_code_n = fcr_we ? fcr_new[7:6] : fcr_r[7:6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcr_r  <= '0;
      flg    <= '0;
      hold   <= '0;
      trig_r <= 1'b0;
      tx_r   <= 1'b0;
    end else begin
      if (fcr_we)  fcr_r <= fcr_new;
      if (nf_push) hold  <= in_byte;
      flg    <= flg_n;
      tx_r   <= tx_clr_c;
      trig_r <= en_n ? (cnt_nxt >= CW'(level_of(lvl_code_n))) : flg_n.ready;
    end
  end

  assign fcr_q        = fcr_r;
  assign fifo_en      = fcr_r[FCR_EN_BIT];
  assign rd_data      = fcr_r[FCR_EN_BIT] ? (q_empty ? 8'h00 : head) : hold;
  assign data_ready   = flg.ready;
  assign overrun      = flg.ovr;
  assign brk_seen     = flg.brk;
  assign timeout_pend = flg.tmo;
  assign trig_hit     = trig_r;
  assign tx_fifo_clr  = tx_r;

  assert_full_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_count == CW'(DEPTH) && in_valid && !rd_en && !fcr_we)
      |=> (overrun && rx_count == CW'(DEPTH)));
  assert_drain_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rd_en && !in_valid && !fcr_we && rx_count == CW'(1))
      |=> (!data_ready && !brk_seen && !timeout_pend && rx_count == '0));
  assert_empty_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && rx_count == '0) |-> (rd_data == 8'h00));
  assert_rx_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fcr_we && (fcr_wdata[1] || (fcr_wdata[0] != fcr_q[0])))
      |=> (rx_count == '0 && !data_ready && !brk_seen && !timeout_pend));
  assert_fcr_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fcr_we |=> (fcr_q == ($past(fcr_wdata) & 8'hC9)));
  assert_break_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_en && in_valid && in_brk && !fcr_we) |=> (data_ready && brk_seen));
  assert_status_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !in_valid) |=> (!overrun && !brk_seen));
  assert_hold_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_en && in_valid && data_ready && !rd_en && !fcr_we) |=> overrun);
endmodule

// File: tb/tb_uart_rx_fifo_ctl.sv
`timescale 1ns/1ps
module tb_uart_rx_fifo_ctl;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH) + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 0, in_brk = 0, rd_en = 0, lsr_rd = 0, fcr_we = 0, baud_tick = 0;
  logic [7:0] in_data = 0, fcr_wdata = 0;
  logic [3:0] lcr_frame = 4'h3;
  logic [7:0] rd_data, fcr_q;
  logic [CW-1:0] rx_count;
  logic fifo_en, trig_hit, data_ready, overrun, brk_seen, timeout_pend, tx_fifo_clr;

  always #2 clk = ~clk;

  uart_rx_fifo_ctl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_brk(in_brk), .in_data(in_data),
    .rd_en(rd_en), .rd_data(rd_data), .lsr_rd(lsr_rd), .fcr_we(fcr_we),
    .fcr_wdata(fcr_wdata), .fcr_q(fcr_q), .lcr_frame(lcr_frame), .baud_tick(baud_tick),
    .fifo_en(fifo_en), .rx_count(rx_count), .trig_hit(trig_hit), .data_ready(data_ready),
    .overrun(overrun), .brk_seen(brk_seen), .timeout_pend(timeout_pend),
    .tx_fifo_clr(tx_fifo_clr)
  );

  int n_chk = 0;
  int n_err = 0;

  // reference state
  logic [7:0] mq[$];
  logic [7:0] m_hold = 0, m_fcr = 0;
  bit m_dr = 0, m_oe = 0, m_bi = 0, m_tp = 0, m_tx = 0;

  task automatic chk(input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  function automatic int lvl_of(input logic [1:0] c);
    case (c)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  function automatic int bits_of(input logic [3:0] lc);
    return 1 + (5 + int'(lc[1:0])) + int'(lc[3]) + (lc[2] ? 2 : 1);
  endfunction

  task automatic model_update(input bit to_exp);
    m_tx = 0;
    if (lsr_rd) begin m_bi = 0; m_oe = 0; end
    if (fcr_we) begin
      bit flip;
      flip = (fcr_wdata[0] != m_fcr[0]);
      if (fcr_wdata[1] || flip) begin
        mq.delete(); m_dr = 0; m_bi = 0; m_tp = 0;
      end
      m_tx  = fcr_wdata[2] || flip;
      m_fcr = fcr_wdata & 8'hC9;
    end else if (m_fcr[0]) begin
      if (rd_en) begin
        m_tp = 0;
        if (mq.size() > 0) void'(mq.pop_front());
      end else if (to_exp) m_tp = 1;
      if (in_valid) begin
        if (mq.size() < DEPTH) mq.push_back(in_brk ? 8'h00 : in_data);
        else m_oe = 1;
        m_dr = 1;
        if (in_brk) m_bi = 1;
      end
      if (rd_en && mq.size() == 0) begin m_dr = 0; m_bi = 0; end
    end else begin
      if (rd_en) begin m_dr = 0; m_bi = 0; end
      if (in_valid) begin
        if (m_dr) m_oe = 1;
        m_hold = in_brk ? 8'h00 : in_data;
        m_dr = 1;
        if (in_brk) m_bi = 1;
      end
    end
  endtask

  task automatic compare_all();
    int exp_trig;
    exp_trig = m_fcr[0] ? int'(mq.size() >= lvl_of(m_fcr[7:6])) : int'(m_dr);
    chk("R12 rx_count", int'(rx_count), mq.size());
    chk("R4 data_ready", int'(data_ready), int'(m_dr));
    chk("R2 overrun", int'(overrun), int'(m_oe));
    chk("R8 brk_seen", int'(brk_seen), int'(m_bi));
    chk("R3 timeout_pend", int'(timeout_pend), int'(m_tp));
    chk("R1 trig_hit", int'(trig_hit), exp_trig);
    chk("R7 fcr_q", int'(fcr_q), int'(m_fcr));
    chk("R6 fifo_en", int'(fifo_en), int'(m_fcr[0]));
    chk("R6 tx_fifo_clr", int'(tx_fifo_clr), int'(m_tx));
  endtask

  task automatic drive_clear();
    in_valid = 0; in_brk = 0; in_data = 0; rd_en = 0; lsr_rd = 0;
    fcr_we = 0; fcr_wdata = 0; baud_tick = 0;
  endtask

  task automatic step(input bit to_exp = 1'b0);
    #1;
    if (rd_en && !fcr_we) begin
      if (m_fcr[0]) chk("R4 rd_data", int'(rd_data), mq.size() > 0 ? int'(mq[0]) : 0);
      else          chk("R11 rd_data", int'(rd_data), int'(m_hold));
    end
    @(posedge clk);
    model_update(to_exp);
    @(negedge clk);
    compare_all();
    drive_clear();
  endtask

  task automatic t_push(input logic [7:0] b); in_valid = 1; in_data = b; step(); endtask
  task automatic t_brk(); in_valid = 1; in_brk = 1; in_data = 8'h5A; step(); endtask
  task automatic t_rd(); rd_en = 1; step(); endtask
  task automatic t_lsr(); lsr_rd = 1; step(); endtask
  task automatic t_fcr(input logic [7:0] w); fcr_we = 1; fcr_wdata = w; step(); endtask
  task automatic t_tick(input bit to_exp = 1'b0); baud_tick = 1; step(to_exp); endtask

  // R3/R9: window of 4 character times in bit ticks
  task automatic t_timeout(input logic [3:0] lc);
    int win;
    lcr_frame = lc;
    win = 4 * bits_of(lc);
    t_fcr(8'h03);
    t_push(8'h3C);
    for (int i = 0; i < win - 1; i++) t_tick();
    chk("R9 no timeout one tick early", int'(timeout_pend), 0);
    t_tick(1'b1);
    chk("R9 timeout on last tick", int'(timeout_pend), 1);
    t_rd();
    chk("R4 read clears timeout", int'(timeout_pend), 0);
    t_rd();
    chk("R4 empty read data", int'(rx_count), 0);
  endtask

  initial begin
    int lim;
    void'($urandom(32'h00C0FFEE));
    drive_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    compare_all();
    chk("R12 rd_data after reset", int'(rd_data), 0);

    // R7 / R6: enable with all bits set
    t_fcr(8'hFF);
    chk("R7 kept bits", int'(fcr_q), 8'hC9);

    // R1 trigger at level 14, R2 overrun on full
    for (int i = 0; i < 13; i++) t_push(8'(8'h10 + i));
    chk("R1 below level", int'(trig_hit), 0);
    t_push(8'h1D);
    chk("R1 at level", int'(trig_hit), 1);
    for (int i = 14; i < 19; i++) t_push(8'(8'h10 + i));
    chk("R2 overrun set", int'(overrun), 1);
    chk("R2 count held", int'(rx_count), DEPTH);
    for (int i = 0; i < DEPTH; i++) t_rd();
    chk("R4 drained ready", int'(data_ready), 0);
    t_lsr();
    chk("R10 overrun cleared", int'(overrun), 0);

    // R8 break, R10 status read clears break only
    t_brk();
    chk("R8 break flag", int'(brk_seen), 1);
    t_lsr();
    chk("R10 break cleared", int'(brk_seen), 0);
    chk("R10 ready kept", int'(data_ready), 1);
    t_rd();

    // R6 transmit-only clear, R5 receive clear
    t_push(8'hA1); t_push(8'hA2);
    t_fcr(8'h05);
    chk("R6 pulse", int'(tx_fifo_clr), 1);
    chk("R6 receive untouched", int'(rx_count), 2);
    t_fcr(8'h03);
    chk("R5 receive cleared", int'(rx_count), 0);

    // R3 / R9 three frame formats
    t_timeout(4'h3);
    t_timeout(4'hF);
    t_timeout(4'h0);

    // R3 read leaving data restarts the window
    lcr_frame = 4'h3;
    lim = 4 * bits_of(4'h3);
    t_fcr(8'h03);
    t_push(8'h61); t_push(8'h62);
    for (int i = 0; i < lim - 5; i++) t_tick();
    t_rd();
    for (int i = 0; i < lim - 1; i++) t_tick();
    chk("R3 restarted by read", int'(timeout_pend), 0);
    t_tick(1'b1);
    chk("R3 expires after restart", int'(timeout_pend), 1);
    t_rd();

    // R11 holding mode
    t_fcr(8'h00);
    t_push(8'h41); t_push(8'h42);
    chk("R11 overrun", int'(overrun), 1);
    t_rd();
    chk("R11 ready cleared", int'(data_ready), 0);
    t_lsr();

    // random mixes at each level, then in holding mode
    for (int lv = 0; lv < 4; lv++) begin
      t_fcr(8'(((lv & 3) << 6) | 8'h03));
      for (int n = 0; n < 400; n++) begin
        in_valid = ($urandom % 100) < 45;
        in_brk   = in_valid && (($urandom % 16) == 0);
        in_data  = 8'($urandom);
        rd_en    = ($urandom % 100) < 35;
        lsr_rd   = ($urandom % 10) == 0;
        step();
      end
    end
    t_fcr(8'h00);
    for (int n = 0; n < 300; n++) begin
      in_valid = ($urandom % 100) < 40;
      in_brk   = in_valid && (($urandom % 16) == 0);
      in_data  = 8'($urandom);
      rd_en    = ($urandom % 100) < 40;
      lsr_rd   = ($urandom % 8) == 0;
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule